// File: doc/BRIEF.md
# Wide Operand Word Port

This block sits between a narrow 32-bit host bus and a scalar-multiplication core that consumes and produces 256-bit field elements. On the load side it holds four wide operand registers: the scalar and the three projective coordinates of the base point. The host picks one register with a 2-bit select and strobes 32-bit words into it. Each word lands in the next slot of that register, starting with the least-significant slot. A start request from the host is passed to the core as a one-cycle launch.

On the unload side the block waits for the core's completion pulse. It copies the three result coordinates into a private shadow copy, then plays them out on a 32-bit port: x, then y, then z, eight words each, least-significant word first. A valid flag is high for exactly 24 cycles. The load path and the unload path are independent, so the next operands can be written while a result is still draining.

The unload controller has two states. `ST_IDLE` goes to `ST_STREAM` when the completion pulse arrives (transition CAPTURE). `ST_STREAM` stays in place while it advances the word index (transition ADVANCE). It returns to `ST_IDLE` after the 24th word (transition DRAINED).

Top module: `wide_operand_port`

## Requirements
- R1: After reset, all four operand registers read zero, `core_start` and `out_go` are low, and `out_word` is zero.
- R2: A cycle with `in_wr` high writes `in_word` into the next word slot of the selected register. Slots fill least-significant first, so eight writes build the full 256-bit value, with the first word in bits 31:0.
- R3: Select encoding: 0 is the scalar, 1 is x, 2 is y and 3 is z. A write changes only the selected register.
- R4: While `in_wr` is low, no register and no slot pointer changes, whatever `in_sel` and `in_word` carry.
- R5: Each register has its own slot pointer, which wraps after eight words. The ninth write to a register overwrites bits 31:0.
- R6: `core_start` is high in the cycle after each cycle in which `act` is high, and low otherwise.
- R7: A `core_done` pulse seen while idle raises `out_go` on the next cycle. `out_go` then stays high for exactly 24 consecutive cycles.
- R8: While `out_go` is high, `out_word` carries x words 0 to 7, then y words 0 to 7, then z words 0 to 7. Word k of a coordinate is bits 32k+31:32k of that coordinate.
- R9: `out_word` is zero whenever `out_go` is low.
- R10: The result is captured at the `core_done` pulse. Later changes on the result inputs, and any `core_done` pulse during streaming, change neither the current stream nor start a new one.
- R11: Operand writes made during streaming take effect normally and do not disturb the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sel | input | 2 | Operand register select |
| in_wr | input | 1 | Write strobe for `in_word` |
| in_word | input | 32 | Incoming operand word |
| act | input | 1 | Start request |
| core_start | output | 1 | Launch pulse to the core |
| core_scalar | output | 256 | Scalar operand |
| core_px | output | 256 | Base point x |
| core_py | output | 256 | Base point y |
| core_pz | output | 256 | Base point z |
| core_done | input | 1 | Core completion pulse |
| core_rx | input | 256 | Result x |
| core_ry | input | 256 | Result y |
| core_rz | input | 256 | Result z |
| out_word | output | 32 | Outgoing result word |
| out_go | output | 1 | Output word valid |

## Verification
A slot pointer that is off by one, or was not reset, shows up as a rotated operand on the `core_*` buses as soon as the first word is written. A wrong select decode corrupts a register that was not addressed, and this is visible in the same cycle. An unload index or FSM fault shows within the 24-cycle window, either as a word out of order or as an `out_go` window that is too short or too long. A shadow that is not held shows up as stream words that follow the live result inputs instead of the values present at `core_done`.

// File: rtl/wop_pkg.sv
package wop_pkg;
    localparam int WORD_BITS  = 32;
    localparam int SLOT_COUNT = 8;
    localparam int OPERANDS   = 4;
    localparam int COORDS     = 3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } unload_state_t;
endpackage

// File: rtl/wop_load_lane.sv
module wop_load_lane #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    localparam int FIELD_W = WORD_W * WORDS,
    localparam int PTR_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  word_in,
    output logic [FIELD_W-1:0] value
);
    logic [PTR_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            value <= '0;
        end else if (wr_en) begin
            value[slot*WORD_W +: WORD_W] <= word_in;
            slot <= (slot == PTR_W'(WORDS-1)) ? '0 : slot + 1'b1;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value) && $stable(slot));

    assert_slot_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == PTR_W'(WORDS-1)) |=> slot == '0);
endmodule

// File: rtl/wop_loader.sv
module wop_loader #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int NREGS  = 4,
    localparam int FIELD_W = WORD_W * WORDS,
    localparam int SEL_W   = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic                          wr,
    input  logic [WORD_W-1:0]             word_in,
    output logic [NREGS-1:0][FIELD_W-1:0] regs
);
    for (genvar g = 0; g < NREGS; g++) begin : g_lane
        logic hit;
        assign hit = wr && (sel == SEL_W'(g));
        wop_load_lane #(.WORD_W(WORD_W), .WORDS(WORDS)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .word_in (word_in),
            .value   (regs[g])
        );

        assert_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel != SEL_W'(g)) |=> $stable(regs[g]));
    end
endmodule

// File: rtl/wop_unloader.sv
module wop_unloader
    import wop_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int NCOORD = 3,
    localparam int FIELD_W = WORD_W * WORDS,
    localparam int TOTAL   = WORDS * NCOORD,
    localparam int IDX_W   = $clog2(TOTAL)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      done_in,
    input  logic [NCOORD*FIELD_W-1:0] res_in,
    output logic [WORD_W-1:0]         out_word,
    output logic                      out_go
);
    unload_state_t             state, state_nx;
    logic [IDX_W-1:0]          idx;
    logic [NCOORD*FIELD_W-1:0] shadow;
    logic                      last_word;

    assign last_word = (idx == IDX_W'(TOTAL-1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (done_in)   state_nx = ST_STREAM;
            ST_STREAM: if (last_word) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            shadow <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (done_in) shadow <= res_in;
                end
                ST_STREAM: idx <= last_word ? '0 : idx + 1'b1;
            endcase
        end
    end

    always_comb begin
        out_go   = 1'b0;
        out_word = '0;
        unique case (state)
            ST_IDLE:   ;
            ST_STREAM: begin
                out_go   = 1'b1;
                out_word = shadow[idx*WORD_W +: WORD_W];
            end
        endcase
    end

    assert_go_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_go) |-> $past(done_in));

    assert_shadow_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_go && $past(out_go)) |-> $stable(shadow));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_go |-> out_word == '0);
endmodule

// File: rtl/wide_operand_port.sv
module wide_operand_port
    import wop_pkg::*;
#(
    parameter int WORD_W = WORD_BITS,
    parameter int WORDS  = SLOT_COUNT,
    localparam int FIELD_W = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         in_sel,
    input  logic               in_wr,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               act,
    output logic               core_start,
    output logic [FIELD_W-1:0] core_scalar,
    output logic [FIELD_W-1:0] core_px,
    output logic [FIELD_W-1:0] core_py,
    output logic [FIELD_W-1:0] core_pz,
    input  logic               core_done,
    input  logic [FIELD_W-1:0] core_rx,
    input  logic [FIELD_W-1:0] core_ry,
    input  logic [FIELD_W-1:0] core_rz,
    output logic [WORD_W-1:0]  out_word,
    output logic               out_go
);
    logic [OPERANDS-1:0][FIELD_W-1:0] op_regs;

    wop_loader #(.WORD_W(WORD_W), .WORDS(WORDS), .NREGS(OPERANDS)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (in_sel),
        .wr      (in_wr),
        .word_in (in_word),
        .regs    (op_regs)
    );

    assign core_scalar = op_regs[0];
    assign core_px     = op_regs[1];
    assign core_py     = op_regs[2];
    assign core_pz     = op_regs[3];

    always_ff @(posedge clk) begin
        if (!rst_n) core_start <= 1'b0;
        else        core_start <= act;
    end

    wop_unloader #(.WORD_W(WORD_W), .WORDS(WORDS), .NCOORD(COORDS)) u_unloader (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_in  (core_done),
        .res_in   ({core_rz, core_ry, core_rx}),
        .out_word (out_word),
        .out_go   (out_go)
    );

    assert_start_from_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_start) |-> $past(act));
endmodule

// File: tb/test_wide_operand_port.sv
module test_wide_operand_port;
    localparam int FW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    in_sel = '0;
    logic          in_wr = 1'b0;
    logic [31:0]   in_word = '0;
    logic          act = 1'b0;
    logic          core_start;
    logic [FW-1:0] core_scalar, core_px, core_py, core_pz;
    logic          core_done = 1'b0;
    logic [FW-1:0] core_rx = '0, core_ry = '0, core_rz = '0;
    logic [31:0]   out_word;
    logic          out_go;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];

    wide_operand_port i_wide_operand_port (
        .clk(clk), .rst_n(rst_n), .in_sel(in_sel), .in_wr(in_wr), .in_word(in_word),
        .act(act), .core_start(core_start), .core_scalar(core_scalar),
        .core_px(core_px), .core_py(core_py), .core_pz(core_pz),
        .core_done(core_done), .core_rx(core_rx), .core_ry(core_ry), .core_rz(core_rz),
        .out_word(out_word), .out_go(out_go)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [FW-1:0] actual, input logic [FW-1:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    function automatic logic [FW-1:0] mkval(input int seed);
        logic [FW-1:0] v;
        for (int k = 0; k < 8; k++)
            v[k*32 +: 32] = (32'(seed) * 32'h9E3779B9) + (32'(k) * 32'h01010101) ^ 32'hA5A50000;
        return v;
    endfunction

    task automatic put_word(input logic [1:0] sel, input logic [31:0] w);
        @(negedge clk);
        in_sel = sel; in_wr = 1'b1; in_word = w;
        @(negedge clk);
        in_wr = 1'b0;
    endtask

    task automatic load_reg(input logic [1:0] sel, input logic [FW-1:0] v);
        for (int k = 0; k < 8; k++) put_word(sel, v[k*32 +: 32]);
    endtask

    task automatic push_result(input logic [FW-1:0] x, y, z);
        for (int k = 0; k < 8; k++) exp_q.push_back(x[k*32 +: 32]);
        for (int k = 0; k < 8; k++) exp_q.push_back(y[k*32 +: 32]);
        for (int k = 0; k < 8; k++) exp_q.push_back(z[k*32 +: 32]);
    endtask

    // monitor / scoreboard (R7, R8, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_go) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 actual=out_go high expected=low (window too long)");
                end else begin
                    chk("R8", FW'(out_word), FW'(exp_q.pop_front()));
                end
            end else if (out_word !== 32'h0) begin
                chk("R9", FW'(out_word), '0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] vs, vx, vy, vz, vy2, ax, ay, az, bx, by, bz;
        vs = mkval(1); vx = mkval(2); vy = mkval(3); vz = mkval(4); vy2 = mkval(5);
        ax = mkval(10); ay = mkval(11); az = mkval(12);
        bx = mkval(20); by = mkval(21); bz = mkval(22);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start", FW'(core_start), '0);
        chk("R1 go", FW'(out_go), '0);
        chk("R1 word", FW'(out_word), '0);
        chk("R1 scalar", core_scalar, '0);
        chk("R1 pz", core_pz, '0);

        // R2 / R4: partial load with idle cycles carrying junk
        for (int k = 0; k < 4; k++) put_word(2'd0, vs[k*32 +: 32]);
        @(negedge clk);
        in_sel = 2'd1; in_word = 32'hDEADBEEF;
        @(negedge clk);
        @(negedge clk);
        chk("R4 no write", core_scalar, {128'h0, vs[127:0]});
        chk("R4 other", core_px, '0);
        for (int k = 4; k < 8; k++) put_word(2'd0, vs[k*32 +: 32]);
        chk("R2 scalar", core_scalar, vs);

        // R3: decode of each select value
        load_reg(2'd1, vx);
        chk("R3 x", core_px, vx);
        chk("R3 scalar kept", core_scalar, vs);
        load_reg(2'd2, vy);
        chk("R3 y", core_py, vy);
        load_reg(2'd3, vz);
        chk("R3 z", core_pz, vz);
        chk("R3 x kept", core_px, vx);

        // R5: ninth write wraps to slot 0
        put_word(2'd1, 32'h13579BDF);
        chk("R5 wrap", core_px, {vx[255:32], 32'h13579BDF});

        // R6
        @(negedge clk); act = 1'b1;
        @(negedge clk); act = 1'b0;
        chk("R6 pulse", FW'(core_start), FW'(1));
        @(negedge clk);
        chk("R6 low", FW'(core_start), '0);

        // R7/R8: first result
        core_rx = ax; core_ry = ay; core_rz = az;
        push_result(ax, ay, az);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
        core_rx = bx; core_ry = by; core_rz = bz;   // R10: live inputs change
        // R11: reload y during the stream
        for (int k = 0; k < 4; k++) put_word(2'd2, vy2[k*32 +: 32]);
        core_done = 1'b1;                           // R10: ignored pulse
        @(negedge clk);
        core_done = 1'b0;
        for (int k = 4; k < 8; k++) put_word(2'd2, vy2[k*32 +: 32]);
        chk("R11 y reload", core_py, vy2);
        wait (exp_q.size() == 0);
        @(negedge clk);
        chk("R7 window end", FW'(out_go), '0);
        repeat (3) @(negedge clk);
        chk("R10 no restart", FW'(out_go), '0);

        // second result
        push_result(bx, by, bz);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
        chk("R7 go rise", FW'(out_go), FW'(1));
        wait (exp_q.size() == 0);
        @(negedge clk);
        chk("R7 second end", FW'(out_go), '0);
        chk("R9 idle word", FW'(out_word), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule